// File: doc/BRIEF.md
# Mode Register Access Engine

This block lets a host read and write the mode registers of an LPDDR2-style memory device through a single register. The host writes a command word holding the mode-register address, the write data, a read/write select and a high-impedance option. The engine then holds a request toward the memory side until the device acknowledges or a programmable time allowance runs out. It reports the outcome in the same register it was commanded through. A done flag tells the host when a new command may be issued. A timeout flag marks an access that received no answer. A read-data field carries the byte returned by a successful read.

The memory side is reduced to a request/acknowledge handshake with address, write data, a direction bit, a high-impedance qualifier and returned read data. Pin timing, the PHY and refresh are outside this block. The time allowance is a separate register counted in units of a fixed number of clocks (16 by default). It is typically left at 3 units and raised for slow commands such as ZQ calibration.

Top module: `mr_access_engine`

## Requirements
- R1: After reset the status word reads done (bit 31) = 1, timeout (bit 29) = 0, read data (bits [27:20]) = 0; the limit register reads 3; `mem_req` and `mem_hiz` are 0.
- R2: Command word fields are: address in bits [7:0], write data in bits [15:8], bit 16 = 1 for a write and 0 for a read, bit 17 = high-impedance option. From the cycle after acceptance these drive `mem_addr`, `mem_wdata` and `mem_we`, stay stable while `mem_req` is high, and are echoed in status bits [17:0].
- R3: A command written while done = 1 is accepted: on the next clock done and timeout read 0 and `mem_req` is 1, and `mem_req` stays 1 until the access ends.
- R4: When `mem_ack` is sampled high while `mem_req` is high, on the next clock `mem_req` is 0, done = 1 and timeout = 0. The read-data field then holds `mem_rdata` for a read and 0 for a write.
- R5: With a limit L, an access that gets no acknowledge within max(L,1)*16 request cycles ends after exactly that many cycles with done = 1, timeout = 1 and read data 0. An acknowledge in the last allowed cycle still counts as success.
- R6: The limit register is written through `lim_wr`/`lim_wdata` and read back on `lim_rdata`. The value present when a command is accepted governs that access, and later writes affect only later accesses.
- R7: A command written while done = 0 is ignored: the memory-side outputs, the pending access and its final status are unchanged.
- R8: `mem_hiz` is 1 only while a write access with bit 17 set is requesting. It stays 0 for reads even when bit 17 is set.
- R9: `mem_ack` while `mem_req` is 0 has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command/status register |
| cmd_wdata | input | 18 | Command word (address, data, write select, high-impedance option) |
| status_rdata | output | 32 | Command/status register read value |
| lim_wr | input | 1 | Write strobe for the timeout limit register |
| lim_wdata | input | LIM_W | New timeout limit in units of 16 clocks |
| lim_rdata | output | LIM_W | Current timeout limit |
| mem_req | output | 1 | Request held during an access |
| mem_we | output | 1 | Access direction, 1 = write |
| mem_hiz | output | 1 | High-impedance qualifier for the write |
| mem_addr | output | 8 | Mode register address |
| mem_wdata | output | 8 | Mode register write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Mode register read data, valid with `mem_ack` |

## Verification
The assertions assume `mem_ack` is a single-cycle pulse in which `mem_rdata` is valid. They also assume that an acknowledge given while no request is pending is harmless noise, not a reply to a past access. The bench raises `mem_ack` for one cycle at a chosen point in the request window, or never, so that both success and timeout paths occur. It also drives stray acknowledges and commands only in the idle and busy windows that R7 and R9 describe. Limits stay small (0 to 4) so that every timeout window is reached within the run. Limit writes are placed both between accesses and inside one, so the snapshot rule of R6 is exercised.

// File: rtl/mr_pkg.sv
package mr_pkg;

  localparam int CMD_W     = 18;
  localparam int STAT_W    = 32;
  localparam int RDATA_LSB = 20;
  localparam int TMO_BIT   = 29;
  localparam int DONE_BIT  = 31;

  typedef struct packed {
    logic       hiz;
    logic       we;
    logic [7:0] wdata;
    logic [7:0] addr;
  } mr_cmd_t;

  typedef enum logic {S_IDLE, S_BUSY} mr_state_t;

  function automatic mr_cmd_t cmd_decode(input logic [CMD_W-1:0] w);
    mr_cmd_t c;
    c.addr  = w[7:0];
    c.wdata = w[15:8];
    c.we    = w[16];
    c.hiz   = w[17];
    return c;
  endfunction

  function automatic logic [STAT_W-1:0] status_pack(input mr_cmd_t c, input logic done,
                                                    input logic tmo, input logic [7:0] rd);
    logic [STAT_W-1:0] s;
    s = '0;
    s[CMD_W-1:0] = c;
    s[RDATA_LSB +: 8] = rd;
    s[TMO_BIT] = tmo;
    s[DONE_BIT] = done;
    return s;
  endfunction

  function automatic logic limit_reached(input logic [31:0] units_done, input logic [31:0] lim);
    return (units_done >= lim);
  endfunction

endpackage

// File: rtl/mr_timeout.sv
module mr_timeout #(
  parameter int LIM_W    = 8,
  parameter int PRESCALE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [LIM_W-1:0] lim,
  output logic             expired
);
  import mr_pkg::*;

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic           unit_tick;
  logic [LIM_W:0] units;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pre <= '0;
        else if (start) pre <= '0;
        else if (run)   pre <= (pre == PW'(PRESCALE-1)) ? '0 : pre + 1'b1;
      end
      assign unit_tick = run && (pre == PW'(PRESCALE-1));
    end else begin : g_nopre
      assign unit_tick = run;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         units <= '0;
    else if (start)     units <= '0;
    else if (unit_tick) units <= units + 1'b1;
  end

  assign expired = unit_tick && limit_reached(32'(units) + 32'd1, 32'(lim));

endmodule

// File: rtl/mr_seq.sv
module mr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic mem_ack,
  input  logic expired,
  output logic accept,
  output logic finish_ok,
  output logic finish_tmo,
  output logic busy
);
  import mr_pkg::*;

  mr_state_t state, state_nx;

  assign busy       = (state == S_BUSY);
  assign accept     = (state == S_IDLE) && cmd_wr;
  assign finish_ok  = busy && mem_ack;
  assign finish_tmo = busy && !mem_ack && expired;

  always_comb begin
    state_nx = state;
    if (accept)                       state_nx = S_BUSY;
    else if (finish_ok || finish_tmo) state_nx = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/mr_cmd_reg.sv
module mr_cmd_reg (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic [mr_pkg::CMD_W-1:0] cmd_in,
  input  logic                   finish_ok,
  input  logic                   finish_tmo,
  input  logic [7:0]             rdata_in,
  output mr_pkg::mr_cmd_t        cmd_q,
  output logic                   tmo_q,
  output logic [7:0]             rd_q
);
  import mr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      tmo_q <= 1'b0;
      rd_q  <= '0;
    end else if (accept) begin
      cmd_q <= cmd_decode(cmd_in);
      tmo_q <= 1'b0;
      rd_q  <= '0;
    end else if (finish_ok) begin
      tmo_q <= 1'b0;
      rd_q  <= cmd_q.we ? 8'h00 : rdata_in;
    end else if (finish_tmo) begin
      tmo_q <= 1'b1;
      rd_q  <= '0;
    end
  end

endmodule

// File: rtl/mr_access_engine.sv
module mr_access_engine #(
  parameter int LIM_W     = 8,
  parameter int PRESCALE  = 16,
  parameter int LIM_RESET = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_wr,
  input  logic [mr_pkg::CMD_W-1:0] cmd_wdata,
  output logic [mr_pkg::STAT_W-1:0] status_rdata,
  input  logic                     lim_wr,
  input  logic [LIM_W-1:0]         lim_wdata,
  output logic [LIM_W-1:0]         lim_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic                     mem_hiz,
  output logic [7:0]               mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic                     mem_ack,
  input  logic [7:0]               mem_rdata
);
  import mr_pkg::*;

  logic             accept, finish_ok, finish_tmo, busy, expired;
  logic [LIM_W-1:0] lim_q, lim_snap;
  mr_cmd_t          cmd_q;
  logic             tmo_q;
  logic [7:0]       rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= LIM_W'(LIM_RESET);
    else if (lim_wr) lim_q <= lim_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_snap <= '0;
    else if (accept) lim_snap <= lim_q;
  end

  mr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .mem_ack(mem_ack), .expired(expired),
    .accept(accept), .finish_ok(finish_ok), .finish_tmo(finish_tmo), .busy(busy)
  );

  mr_timeout #(.LIM_W(LIM_W), .PRESCALE(PRESCALE)) u_tmo (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy), .lim(lim_snap), .expired(expired)
  );

  mr_cmd_reg u_reg (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_in(cmd_wdata),
    .finish_ok(finish_ok), .finish_tmo(finish_tmo), .rdata_in(mem_rdata),
    .cmd_q(cmd_q), .tmo_q(tmo_q), .rd_q(rd_q)
  );

  assign status_rdata = status_pack(cmd_q, !busy, tmo_q, rd_q);
  assign lim_rdata    = lim_q;
  assign mem_req      = busy;
  assign mem_we       = cmd_q.we;
  assign mem_hiz      = busy && cmd_q.we && cmd_q.hiz;
  assign mem_addr     = cmd_q.addr;
  assign mem_wdata    = cmd_q.wdata;

endmodule

// File: rtl/mr_access_chk.sv
module mr_access_chk #(
  parameter int LIM_W    = 8,
  parameter int PRESCALE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic             accept,
  input logic [31:0]      status,
  input logic [LIM_W-1:0] lim_rdata,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_hiz,
  input logic [7:0]       mem_addr,
  input logic [7:0]       mem_wdata,
  input logic             mem_ack
);
  logic [31:0] cnt_q, tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgt_q <= 32'd1;
    end else if (accept) begin
      cnt_q <= '0;
      tgt_q <= ((lim_rdata == '0) ? 32'd1 : 32'(lim_rdata)) * PRESCALE;
    end else if (mem_req) begin
      cnt_q <= cnt_q + 32'd1;
    end
  end

  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && status[31]) |=> (!status[31] && !status[29] && mem_req));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !status[31]) |=> ($stable(mem_addr) && $stable(mem_we)));

  assert_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (status[31] && !status[29] && !mem_req));

  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cnt_q < tgt_q));

  assert_tmo_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[29]) |-> (cnt_q == tgt_q));

  assert_tmo_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[29] |-> status[31]);

  assert_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hiz |-> (mem_req && mem_we));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !cmd_wr) |=> $stable(status));

endmodule

bind mr_access_engine mr_access_chk #(.LIM_W(LIM_W), .PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .accept(accept), .status(status_rdata),
  .lim_rdata(lim_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_hiz(mem_hiz),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/tb_mr_access_engine.sv
module tb_mr_access_engine;
  localparam int LIM_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_wr = 1'b0;
  logic [17:0]      cmd_wdata = '0;
  logic [31:0]      status_rdata;
  logic             lim_wr = 1'b0;
  logic [LIM_W-1:0] lim_wdata = '0;
  logic [LIM_W-1:0] lim_rdata;
  logic             mem_req, mem_we, mem_hiz;
  logic [7:0]       mem_addr, mem_wdata;
  logic             mem_ack = 1'b0;
  logic [7:0]       mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cur_lim = 3;
  bit finished = 0;

  always #10 clk = ~clk;

  mr_access_engine #(.LIM_W(LIM_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .status_rdata(status_rdata), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
    .lim_rdata(lim_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_hiz(mem_hiz),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] exp_status(input logic [17:0] w, input bit dn,
                                             input bit tm, input logic [7:0] rd);
    return (32'(dn) << 31) | (32'(tm) << 29) | (32'(rd) << 20) | 32'(w);
  endfunction

  function automatic int window(input int lim);
    return (lim < 1 ? 1 : lim) * 16;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_limit(input int v);
    @(negedge clk); lim_wr = 1'b1; lim_wdata = LIM_W'(v);
    @(negedge clk); lim_wr = 1'b0;
    cur_lim = v;
    chk(lim_rdata == LIM_W'(v), "R6 limit readback", 32'(lim_rdata), 32'(v));
  endtask

  // d < 0: never acknowledge
  task automatic run_access(input logic [17:0] word, input int d, input bit intrude,
                            input bit chg_lim, input int new_lim);
    int t;
    bit ok;
    logic [7:0] rd;
    logic [31:0] exp;
    t = window(cur_lim);
    rd = 8'($urandom_range(0, 255));
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = word;
    @(negedge clk); cmd_wr = 1'b0;
    chk(status_rdata[31] == 1'b0 && status_rdata[29] == 1'b0, "R3 accept clears done",
        status_rdata, exp_status(word, 0, 0, 0));
    chk(mem_req == 1'b1, "R3 request raised", 32'(mem_req), 32'd1);
    chk(mem_addr == word[7:0] && mem_wdata == word[15:8] && mem_we == word[16], "R2 fields",
        {15'd0, mem_we, mem_wdata, mem_addr}, 32'(word[16:0]));
    chk(mem_hiz == (word[16] && word[17]), "R8 hiz qualifier", 32'(mem_hiz),
        32'(word[16] && word[17]));
    for (int k = 0; k < 100000; k++) begin
      chk(mem_req == 1'b1 && status_rdata[31] == 1'b0, "R3 busy held",
          {31'd0, mem_req}, 32'd1);
      if (intrude && k == 1) begin cmd_wr = 1'b1; cmd_wdata = ~word; end
      if (chg_lim && k == 1) begin lim_wr = 1'b1; lim_wdata = LIM_W'(new_lim); end
      if (k == d) begin mem_ack = 1'b1; mem_rdata = rd; end
      @(negedge clk);
      cmd_wr = 1'b0; lim_wr = 1'b0; mem_ack = 1'b0;
      mem_rdata = 8'($urandom_range(0, 255));
      if (intrude && k == 1)
        chk(mem_addr == word[7:0] && mem_we == word[16], "R7 busy command ignored",
            32'(mem_addr), 32'(word[7:0]));
      if (k == d || k == t - 1) break;
    end
    if (chg_lim) cur_lim = new_lim;
    ok = (d >= 0 && d < t);
    exp = exp_status(word, 1, !ok, (ok && !word[16]) ? rd : 8'h00);
    chk(status_rdata == exp, ok ? "R4 completion status" : "R5 timeout status",
        status_rdata, exp);
    chk(mem_req == 1'b0 && mem_hiz == 1'b0, "R4 request dropped", {30'd0, mem_req, mem_hiz}, 32'd0);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status_rdata == 32'h8000_0000, "R1 reset status", status_rdata, 32'h8000_0000);
    chk(lim_rdata == 8'd3, "R1 reset limit", 32'(lim_rdata), 32'd3);
    chk(mem_req == 1'b0 && mem_hiz == 1'b0, "R1 idle outputs", {30'd0, mem_req, mem_hiz}, 32'd0);

    run_access(18'h0_0005, 0, 0, 0, 0);            // R4 read, immediate ack
    run_access(18'h3_FF0A, 5, 0, 0, 0);            // R8 write with hiz
    run_access(18'h2_1208, 3, 0, 0, 0);            // R8 read with hiz bit: no hiz
    run_access(18'h0_0008, -1, 0, 0, 0);           // R5 timeout at 48 cycles
    run_access(18'h1_4402, 47, 0, 0, 0);           // R5 ack in last allowed cycle
    run_access(18'h0_0011, -1, 0, 1, 0);           // R6 limit change mid-access: still 48
    chk(lim_rdata == 8'd0, "R6 new limit visible", 32'(lim_rdata), 32'd0);
    run_access(18'h0_0013, -1, 0, 0, 0);           // R5 limit 0 -> 16 cycles
    run_access(18'h0_0014, 15, 0, 0, 0);           // R5 limit 0, last cycle ack
    set_limit(2);
    run_access(18'h0_0021, 9, 1, 0, 0);            // R7 busy command ignored

    // R9 stray acknowledge while idle
    keep = status_rdata;
    @(negedge clk); mem_ack = 1'b1; mem_rdata = ~keep[27:20];
    @(negedge clk); mem_ack = 1'b0;
    chk(status_rdata == keep && mem_req == 1'b0, "R9 idle ack ignored", status_rdata, keep);

    for (int i = 0; i < 40; i++) begin
      int d;
      if ($urandom_range(0, 3) == 0) set_limit($urandom_range(0, 4));
      d = $urandom_range(0, window(cur_lim) + 4);
      if ($urandom_range(0, 4) == 0) d = -1;
      run_access(18'($urandom), d, $urandom_range(0, 3) == 0, 0, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule